// File: doc/BRIEF.md
# Compare Flags and Branch Resolver

This block keeps the processor's 32-bit status word and decides conditional jumps. When a compare operation is presented, it orders two 32-bit operands as signed numbers and records five relational flags plus a Zero flag. When the result of an arithmetic, logic, shift or move operation is presented, only the Zero flag changes, and it reflects whether that result is zero. The flag word updates on the clock edge while the write enable is high.

For jumps, the block looks at the current jump opcode and the registered flags, and raises a combinational taken signal. It also forms the target address as a base register value plus a sign-extended 16-bit offset. A zero base gives an absolute target, and a program-counter base gives a relative one. The program counter itself and the fetch redirection sit outside this block.

Top module: `cond_flag_unit`

## Requirements
- R1: After reset every status bit is 0, and bits 31 down to 6 of the status word read 0 at all times.
- R2: With update enabled and class 2'b01 (compare), the next status is bit0 = (a == b), bit1 = a > b, bit2 = a >= b, bit3 = a < b and bit4 = a <= b, all signed, and bit5 equals bit0.
- R3: With update enabled and class 2'b10 (result), bit5 becomes 1 exactly when the result is zero, and bits 4 to 0 keep their previous values.
- R4: The status word does not change while update is low, or when the class is 2'b00 or 2'b11.
- R5: Opcode 0x0D is always taken. Opcode 0x0E is taken when bit0 is set, and opcode 0x0F is taken when bit0 is clear.
- R6: Opcode 0x10 is taken on bit1, 0x11 on bit1 or bit0, 0x12 on bit3, and 0x13 on bit3 or bit0.
- R7: Every opcode outside 0x0D to 0x13 gives taken = 0.
- R8: The target equals the base plus the sign-extended 16-bit offset, modulo 2^32, whether or not the jump is taken.
- R9: Taken is decided combinationally from the registered status, so a compare affects jumps from the cycle after it is written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| upd_en | input | 1 | Status write enable |
| op_cls | input | 2 | Operation class: 00 none, 01 compare, 10 result, 11 none |
| opnd_a | input | 32 | First compare operand |
| opnd_b | input | 32 | Second compare operand |
| result | input | 32 | Arithmetic, logic, shift or move result |
| br_opcode | input | 6 | Current jump opcode |
| br_base | input | 32 | Base register value for the target |
| br_offset | input | 16 | Signed target offset |
| status_q | output | 32 | Registered status word |
| br_taken | output | 1 | Jump taken |
| br_target | output | 32 | Jump target address |

## Verification
The assertions assume that every input is settled at each rising clock edge, and that the status word is only meant to change through a write-enabled compare or result class. The bench changes every input on the falling edge and holds it through the following rising edge. It drops the enable after exactly one edge, so each write is a single update whose effect can be sampled at the next falling edge. Jump inputs are applied while the enable is low, which means the taken signal is always judged against a stable, known flag word.

// File: rtl/cfu_pkg.sv
package cfu_pkg;
    localparam int FLAG_N = 6;
    localparam int OPC_W  = 6;

    // Flag positions: jump decoding depends on this layout
    localparam int F_EQ = 0;
    localparam int F_GT = 1;
    localparam int F_GE = 2;
    localparam int F_LT = 3;
    localparam int F_LE = 4;
    localparam int F_ZR = 5;

    typedef enum logic [1:0] {
        CLS_NONE = 2'b00,
        CLS_CMP  = 2'b01,
        CLS_RES  = 2'b10,
        CLS_RSVD = 2'b11
    } op_cls_e;

    localparam logic [OPC_W-1:0] OPC_JMP = 6'h0D;
    localparam logic [OPC_W-1:0] OPC_JEQ = 6'h0E;
    localparam logic [OPC_W-1:0] OPC_JNE = 6'h0F;
    localparam logic [OPC_W-1:0] OPC_JGT = 6'h10;
    localparam logic [OPC_W-1:0] OPC_JGE = 6'h11;
    localparam logic [OPC_W-1:0] OPC_JLT = 6'h12;
    localparam logic [OPC_W-1:0] OPC_JLE = 6'h13;

    typedef struct packed {
        logic [FLAG_N-1:0] flags;
    } flag_state_t;
endpackage

// File: rtl/cfu_compare.sv
module cfu_compare
    import cfu_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0] opnd_a,
    input  logic [DATA_W-1:0] opnd_b,
    input  logic [DATA_W-1:0] result,
    output logic [FLAG_N-1:0] cmp_flags,
    output logic              res_zero
);
    logic same;
    logic above;

    always_comb begin
        same  = (opnd_a == opnd_b);
        above = ($signed(opnd_a) > $signed(opnd_b));
        cmp_flags       = '0;
        cmp_flags[F_EQ] = same;
        cmp_flags[F_GT] = above;
        cmp_flags[F_GE] = above | same;
        cmp_flags[F_LT] = ~(above | same);
        cmp_flags[F_LE] = ~above;
        cmp_flags[F_ZR] = same;
        res_zero        = (result == '0);
    end
endmodule

// File: rtl/cfu_branch.sv
module cfu_branch
    import cfu_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int OFS_W  = 16
) (
    input  logic [FLAG_N-1:0] flags,
    input  logic [OPC_W-1:0]  br_opcode,
    input  logic [DATA_W-1:0] br_base,
    input  logic [OFS_W-1:0]  br_offset,
    output logic              br_taken,
    output logic [DATA_W-1:0] br_target
);
    localparam int EXT_W = DATA_W - OFS_W;

    logic [DATA_W-1:0] ofs_ext;

    always_comb begin
        ofs_ext   = {{EXT_W{br_offset[OFS_W-1]}}, br_offset};
        br_target = br_base + ofs_ext;
        unique case (br_opcode)
            OPC_JMP: br_taken = 1'b1;
            OPC_JEQ: br_taken = flags[F_EQ];
            OPC_JNE: br_taken = ~flags[F_EQ];
            OPC_JGT: br_taken = flags[F_GT];
            OPC_JGE: br_taken = flags[F_GT] | flags[F_EQ];
            OPC_JLT: br_taken = flags[F_LT];
            OPC_JLE: br_taken = flags[F_LT] | flags[F_EQ];
            default: br_taken = 1'b0;
        endcase
    end
endmodule

// File: rtl/cond_flag_unit.sv
module cond_flag_unit
    import cfu_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int OFS_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              upd_en,
    input  logic [1:0]        op_cls,
    input  logic [DATA_W-1:0] opnd_a,
    input  logic [DATA_W-1:0] opnd_b,
    input  logic [DATA_W-1:0] result,
    input  logic [5:0]        br_opcode,
    input  logic [DATA_W-1:0] br_base,
    input  logic [OFS_W-1:0]  br_offset,
    output logic [DATA_W-1:0] status_q,
    output logic              br_taken,
    output logic [DATA_W-1:0] br_target
);
    localparam int PAD_W = DATA_W - FLAG_N;

    flag_state_t       st_d;
    flag_state_t       st_q;
    logic [FLAG_N-1:0] cmp_flags;
    logic              res_zero;
    op_cls_e           cls;

    cfu_compare #(.DATA_W(DATA_W)) cmp_i (
        .opnd_a    (opnd_a),
        .opnd_b    (opnd_b),
        .result    (result),
        .cmp_flags (cmp_flags),
        .res_zero  (res_zero)
    );

    always_comb begin
        cls  = op_cls_e'(op_cls);
        st_d = st_q;
        if (upd_en) begin
            unique case (cls)
                CLS_CMP: st_d.flags       = cmp_flags;
                CLS_RES: st_d.flags[F_ZR] = res_zero;
                default: st_d = st_q;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign status_q = {{PAD_W{1'b0}}, st_q.flags};

    cfu_branch #(.DATA_W(DATA_W), .OFS_W(OFS_W)) br_i (
        .flags     (st_q.flags),
        .br_opcode (br_opcode),
        .br_base   (br_base),
        .br_offset (br_offset),
        .br_taken  (br_taken),
        .br_target (br_target)
    );
endmodule

// File: rtl/cfu_checker.sv
module cfu_checker #(
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              upd_en,
    input logic [1:0]        op_cls,
    input logic [DATA_W-1:0] result,
    input logic [5:0]        br_opcode,
    input logic [DATA_W-1:0] status_q,
    input logic              br_taken
);
    // R1
    rsvd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        status_q[DATA_W-1:6] == '0);

    // R2
    cmp_zero_eq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_en && op_cls == 2'b01) |=> (status_q[5] == status_q[0]));

    // R2
    cmp_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_en && op_cls == 2'b01) |=> ($countones({status_q[0], status_q[1], status_q[3]}) == 1));

    // R3
    res_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_en && op_cls == 2'b10) |=> (status_q[4:0] == $past(status_q[4:0])));

    // R3
    res_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_en && op_cls == 2'b10) |=> (status_q[5] == ($past(result) == '0)));

    // R4
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!upd_en || op_cls == 2'b00 || op_cls == 2'b11) |=> $stable(status_q));

    // R5
    jmp_always_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (br_opcode == 6'h0D) |-> br_taken);

    // R7
    non_branch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (br_opcode < 6'h0D || br_opcode > 6'h13) |-> !br_taken);
endmodule

bind cond_flag_unit cfu_checker #(.DATA_W(DATA_W)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .upd_en    (upd_en),
    .op_cls    (op_cls),
    .result    (result),
    .br_opcode (br_opcode),
    .status_q  (status_q),
    .br_taken  (br_taken)
);

// File: tb/cond_flag_unit_tb_top.sv
module cond_flag_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        upd_en = 1'b0;
    logic [1:0]  op_cls = 2'b00;
    logic [31:0] opnd_a = '0;
    logic [31:0] opnd_b = '0;
    logic [31:0] result = '0;
    logic [5:0]  br_opcode = 6'h00;
    logic [31:0] br_base = '0;
    logic [15:0] br_offset = '0;
    logic [31:0] status_q;
    logic        br_taken;
    logic [31:0] br_target;

    int n_chk = 0;
    int n_bad = 0;
    logic [5:0] mflags = '0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    cond_flag_unit dut_i (
        .clk(clk), .rst_n(rst_n), .upd_en(upd_en), .op_cls(op_cls),
        .opnd_a(opnd_a), .opnd_b(opnd_b), .result(result),
        .br_opcode(br_opcode), .br_base(br_base), .br_offset(br_offset),
        .status_q(status_q), .br_taken(br_taken), .br_target(br_target)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    function automatic logic model_taken(input logic [5:0] opc, input logic [5:0] f);
        case (opc)
            6'h0D: return 1'b1;
            6'h0E: return f[0];
            6'h0F: return !f[0];
            6'h10: return f[1];
            6'h11: return f[1] || f[0];
            6'h12: return f[3];
            6'h13: return f[3] || f[0];
            default: return 1'b0;
        endcase
    endfunction

    // One write cycle; status sampled at the falling edge after the update
    task automatic write_op(input logic en, input logic [1:0] cls,
                            input logic [31:0] a, input logic [31:0] b,
                            input logic [31:0] r);
        @(negedge clk);
        upd_en = en; op_cls = cls; opnd_a = a; opnd_b = b; result = r;
        @(negedge clk);
        upd_en = 1'b0;
        if (en && cls == 2'b01) begin
            mflags[0] = (a == b);
            mflags[1] = ($signed(a) > $signed(b));
            mflags[2] = ($signed(a) >= $signed(b));
            mflags[3] = ($signed(a) < $signed(b));
            mflags[4] = ($signed(a) <= $signed(b));
            mflags[5] = (a == b);
        end else if (en && cls == 2'b10) begin
            mflags[5] = (r == 32'h0);
        end
    endtask

    task automatic t_reset();
        check("R1 reset status", status_q, 32'h0);
        br_opcode = 6'h0E; #1;
        check("R5 JEQ after reset", {31'h0, br_taken}, 32'h0);
        br_opcode = 6'h0F; #1;
        check("R5 JNE after reset", {31'h0, br_taken}, 32'h1);
        br_opcode = 6'h00;
    endtask

    task automatic t_compare();
        write_op(1'b1, 2'b01, 32'd5, 32'd3, 32'h0);
        check("R2 cmp 5 vs 3", status_q, 32'h06);
        write_op(1'b1, 2'b01, 32'd3, 32'd5, 32'h0);
        check("R2 cmp 3 vs 5", status_q, 32'h18);
        write_op(1'b1, 2'b01, 32'd7, 32'd7, 32'h0);
        check("R2 cmp equal", status_q, 32'h35);
        write_op(1'b1, 2'b01, 32'hFFFF_FFFF, 32'd1, 32'h0);
        check("R2 cmp signed -1 vs 1", status_q, 32'h18);
        write_op(1'b1, 2'b01, 32'h8000_0000, 32'h7FFF_FFFF, 32'h0);
        check("R2 cmp most negative", status_q, 32'h18);
        write_op(1'b1, 2'b01, 32'h7FFF_FFFF, 32'h8000_0000, 32'h0);
        check("R2 cmp most positive", status_q, {26'h0, mflags});
    endtask

    task automatic t_result();
        write_op(1'b1, 2'b01, 32'd9, 32'd2, 32'h0);
        write_op(1'b1, 2'b10, 32'd0, 32'd0, 32'h0);
        check("R3 zero result keeps relational", status_q, 32'h26);
        write_op(1'b1, 2'b10, 32'd0, 32'd0, 32'h0000_0100);
        check("R3 nonzero result", status_q, 32'h06);
        write_op(1'b1, 2'b01, 32'd4, 32'd4, 32'h0);
        write_op(1'b1, 2'b10, 32'd1, 32'd2, 32'h8000_0000);
        check("R3 clears zero after equal", status_q, 32'h15);
    endtask

    task automatic t_hold();
        write_op(1'b0, 2'b01, 32'd1, 32'd9, 32'h0);
        check("R4 enable low", status_q, 32'h15);
        write_op(1'b1, 2'b00, 32'd1, 32'd9, 32'h0);
        check("R4 class none", status_q, 32'h15);
        write_op(1'b1, 2'b11, 32'd1, 32'd9, 32'h0);
        check("R4 class reserved", status_q, 32'h15);
        write_op(1'b0, 2'b10, 32'd0, 32'd0, 32'h0);
        check("R4 result with enable low", status_q, 32'h15);
    endtask

    task automatic sweep_branches(input string tag);
        for (int op = 0; op < 64; op++) begin
            br_opcode = op[5:0]; #1;
            if (op >= 13 && op <= 15)
                check({"R5 ", tag}, {31'h0, br_taken}, {31'h0, model_taken(op[5:0], mflags)});
            else if (op >= 16 && op <= 19)
                check({"R6 ", tag}, {31'h0, br_taken}, {31'h0, model_taken(op[5:0], mflags)});
            else
                check({"R7 ", tag}, {31'h0, br_taken}, 32'h0);
        end
        br_opcode = 6'h00;
    endtask

    task automatic t_branch();
        write_op(1'b1, 2'b01, 32'd10, 32'hFFFF_FFF0, 32'h0);
        sweep_branches("after greater");
        write_op(1'b1, 2'b01, 32'hFFFF_FFF0, 32'd10, 32'h0);
        sweep_branches("after less");
        write_op(1'b1, 2'b01, 32'd42, 32'd42, 32'h0);
        sweep_branches("after equal");
        write_op(1'b1, 2'b10, 32'd0, 32'd0, 32'd3);
        sweep_branches("after result");
    endtask

    task automatic t_timing();
        write_op(1'b1, 2'b01, 32'd1, 32'd2, 32'h0);
        br_opcode = 6'h10;
        @(negedge clk);
        upd_en = 1'b1; op_cls = 2'b01; opnd_a = 32'd2; opnd_b = 32'd1;
        #1;
        check("R9 taken before edge uses old flags", {31'h0, br_taken}, 32'h0);
        @(negedge clk);
        upd_en = 1'b0;
        check("R9 taken after edge uses new flags", {31'h0, br_taken}, 32'h1);
        br_opcode = 6'h00;
        mflags = 6'h06;
    endtask

    task automatic t_target();
        br_opcode = 6'h0D; br_base = 32'h0000_1000; br_offset = 16'hFFFC; #1;
        check("R8 negative offset", br_target, 32'h0000_0FFC);
        br_base = 32'h0; br_offset = 16'h7FFF; #1;
        check("R8 absolute from zero base", br_target, 32'h0000_7FFF);
        br_base = 32'hFFFF_FFF0; br_offset = 16'h0020; #1;
        check("R8 wraparound", br_target, 32'h0000_0010);
        br_base = 32'h0001_0000; br_offset = 16'h8000; #1;
        check("R8 most negative offset", br_target, 32'h0000_8000);
        br_opcode = 6'h0E; br_base = 32'h0000_2000; br_offset = 16'h0010; #1;
        check("R8 target when not taken", br_target, 32'h0000_2010);
        br_opcode = 6'h3F; #1;
        check("R8 target for non-branch opcode", br_target, 32'h0000_2010);
        br_opcode = 6'h00;
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 10);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 status after release", status_q, 32'h0);
        t_compare();
        t_result();
        t_hold();
        t_branch();
        t_timing();
        t_target();
        finish_run();
    end
endmodule